// File: doc/BRIEF.md
# Link Boot and Memory-Access Loader

This block performs a processor's boot-from-link sequence after reset. Four byte-wide receive ports each latch incoming bytes into a one-byte holding register. Once started, the loader scans these holding registers in turn. The first byte that arrives on a link decides what happens next:

- **Zero:** a word write into memory.
- **One:** a word read, with the result sent back on the same link.
- **Two or more:** a bootstrap load of that many bytes into memory, starting at the load base.

Any number of reads and writes may come in on any links before the bootstrap load. After the bootstrap load starts, the loader serves only that link until the load is finished. When it is done, it presents the entry address, the link used, the first free workspace word and a low-priority flag. A strap input selects booting from ROM instead. In that case the loader skips the links and reports the fixed ROM entry point.

Before each command, the loader reads the word at the load base and keeps it. The command byte is written into that location as scratch. The kept word is then written back before the command runs. As a result, the load base location looks untouched to any later read or write from a link.

Top module: `link_boot_loader`

## Requirements
- R1: While `rst` is high, `done` is low, no memory request or transmit byte is issued, and every `rx_full` flag is held clear, even if `rx_valid` pulses.
- R2: Links are examined one per cycle in the order 0, 1, 2, 3, then back to 0. After `start` the scan begins at link 0. After a read or write has been serviced, the scan resumes at the link following the one served. When several links hold command bytes, the first one reached is served first.
- R3: Command byte 0 is followed on the same link by four address bytes, then four data bytes, each word least significant byte first. The data word is then written to the word-aligned address with `mem_be` = 4'b1111.
- R4: Command byte 1 is followed by four address bytes (least significant byte first). The word at that address is read and sent back on the same link's `tx_valid` bit, one byte per cycle, least significant byte first. At most one `tx_valid` bit is high at a time.
- R5: A command byte N of 2 or more is followed by N bytes. Byte k is written to byte address MEM_START+k, to the word-aligned address, with the single enable bit at position (MEM_START+k) mod 4. Other byte lanes are untouched.
- R6: While a bootstrap load is in progress, bytes held on other links are not consumed (their `rx_full` stays high), and no read or write command is carried out.
- R7: When the last bootstrap byte is written, `done` rises and stays high until reset. At the same time `boot_iptr` = MEM_START, `boot_link` = the loading link, `boot_wptr` = (MEM_START+N+3) with the two low bits cleared, `low_pri` = 1 and `from_rom` = 0.
- R8: If `rom_boot` is high when `start` is taken, then in the next cycle `done` = 1, `from_rom` = 1, `boot_iptr` = MAX_INT-2 and `boot_wptr` = MEM_START. In that case no link byte is consumed and memory is not touched.
- R9: Before each command the word at MEM_START is read and kept. The command byte is written to its lane 0, and the kept word is written back before the command proceeds. A read of MEM_START therefore returns the original word, and the word is unchanged after reads.
- R10: An `rx_valid` pulse on link i sets `rx_full[i]` and holds `rx_byte[8i+7:8i]` until the loader consumes it, whether or not the loader is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin the boot sequence (taken when idle) |
| rom_boot | input | 1 | Strap: boot from ROM, skip links |
| rx_valid | input | NLINK | One-cycle strobe of a received byte per link |
| rx_byte | input | 8*NLINK | Received bytes, link i in bits 8i+7:8i |
| rx_full | output | NLINK | Holding register of link i occupied |
| tx_valid | output | NLINK | Transmit strobe per link |
| tx_byte | output | 8 | Byte being transmitted |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte write enables |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| done | output | 1 | Boot sequence complete (sticky) |
| from_rom | output | 1 | Completion came from the ROM strap |
| low_pri | output | 1 | Start the booted process at low priority |
| boot_iptr | output | 32 | Entry address |
| boot_wptr | output | 32 | Workspace pointer |
| boot_link | output | $clog2(NLINK) | Link that delivered the bootstrap |

## Verification
The properties assume that a link never raises `rx_valid` while its `rx_full` flag is set. They also assume that memory returns read data exactly one cycle after the request. The stimulus honours the first point because each per-link sender waits at the falling edge until the flag is clear before it strobes a byte. It honours the second point because the bench memory model is a register that is updated on the rising edge. Reads and writes are queued as expected replies by the sending tasks and matched in arrival order against the bytes on `tx_valid`. This is how the scan order across links is observed.

// File: rtl/link_boot_loader.sv
module link_boot_loader #(
  parameter int NLINK = 4,
  parameter logic [31:0] MEM_START = 32'h8000_0070,
  parameter logic [31:0] MAX_INT = 32'h7FFF_FFFF,
  localparam int LW = $clog2(NLINK)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 rom_boot,
  input  logic [NLINK-1:0]     rx_valid,
  input  logic [8*NLINK-1:0]   rx_byte,
  output logic [NLINK-1:0]     rx_full,
  output logic [NLINK-1:0]     tx_valid,
  output logic [7:0]           tx_byte,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [31:0]          mem_addr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_be,
  input  logic [31:0]          mem_rdata,
  output logic                 done,
  output logic                 from_rom,
  output logic                 low_pri,
  output logic [31:0]          boot_iptr,
  output logic [31:0]          boot_wptr,
  output logic [LW-1:0]        boot_link
);

  typedef enum logic [3:0] {
    S_IDLE, S_SAVE_RD, S_SAVE_WT, S_POLL, S_SCRATCH, S_RESTORE,
    S_GET_ADDR, S_GET_DATA, S_POKE, S_PEEK_RD, S_PEEK_WT, S_PEEK_TX,
    S_NEXT, S_LOAD, S_DONE
  } st_t;

  st_t            state;
  logic [LW-1:0]  ptr, sel;
  logic [7:0]     hold [NLINK];
  logic [NLINK-1:0] take;
  logic [7:0]     first, cnt, len;
  logic [31:0]    sh, addr_q, saved;

  wire [7:0]  cur       = hold[sel];
  wire [31:0] nsh       = {cur, sh[31:8]};
  wire [31:0] load_addr = MEM_START + {24'b0, cnt};
  wire [31:0] end_wptr  = (MEM_START + {24'b0, len} + 32'd3) & ~32'd3;
  wire        sel_full  = rx_full[sel];

  function automatic logic [LW-1:0] nxt(input logic [LW-1:0] p);
    return (p == LW'(NLINK - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    take = '0;
    if (state == S_POLL && rx_full[ptr]) take[ptr] = 1'b1;
    if ((state == S_GET_ADDR || state == S_GET_DATA || state == S_LOAD) && sel_full)
      take[sel] = 1'b1;
  end

  for (genvar i = 0; i < NLINK; i++) begin : g_rx
    always_ff @(posedge clk) begin
      if (rst) begin
        rx_full[i] <= 1'b0;
        hold[i]    <= '0;
      end else if (take[i]) begin
        rx_full[i] <= 1'b0;
      end else if (rx_valid[i]) begin
        rx_full[i] <= 1'b1;
        hold[i]    <= rx_byte[8*i +: 8];
      end
    end

    assert_no_overrun_R10: assert property (@(posedge clk) disable iff (rst)
      rx_valid[i] |-> !rx_full[i]);

    assert_locked_link_R6: assert property (@(posedge clk) disable iff (rst)
      (state == S_LOAD && rx_full[i] && sel != LW'(i)) |=> rx_full[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ptr <= '0; sel <= '0;
      first <= '0; cnt <= '0; len <= '0;
      sh <= '0; addr_q <= '0; saved <= '0;
      done <= 1'b0; from_rom <= 1'b0; low_pri <= 1'b0;
      boot_iptr <= '0; boot_wptr <= '0; boot_link <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          ptr <= '0;
          if (rom_boot) begin
            state     <= S_DONE;
            done      <= 1'b1;
            from_rom  <= 1'b1;
            low_pri   <= 1'b1;
            boot_iptr <= MAX_INT - 32'd2;
            boot_wptr <= MEM_START;
            boot_link <= '0;
          end else state <= S_SAVE_RD;
        end
        S_SAVE_RD: state <= S_SAVE_WT;
        S_SAVE_WT: begin
          saved <= mem_rdata;
          state <= S_POLL;
        end
        S_POLL: if (rx_full[ptr]) begin
          sel   <= ptr;
          first <= hold[ptr];
          state <= S_SCRATCH;
        end else ptr <= nxt(ptr);
        S_SCRATCH: state <= S_RESTORE;
        S_RESTORE: begin
          cnt <= '0;
          len <= first;
          state <= (first >= 8'd2) ? S_LOAD : S_GET_ADDR;
        end
        S_GET_ADDR: if (sel_full) begin
          sh  <= nsh;
          cnt <= cnt + 8'd1;
          if (cnt == 8'd3) begin
            addr_q <= nsh;
            cnt    <= '0;
            state  <= (first == 8'd0) ? S_GET_DATA : S_PEEK_RD;
          end
        end
        S_GET_DATA: if (sel_full) begin
          sh  <= nsh;
          cnt <= cnt + 8'd1;
          if (cnt == 8'd3) state <= S_POKE;
        end
        S_POKE: state <= S_NEXT;
        S_PEEK_RD: state <= S_PEEK_WT;
        S_PEEK_WT: begin
          sh    <= mem_rdata;
          cnt   <= '0;
          state <= S_PEEK_TX;
        end
        S_PEEK_TX: begin
          sh  <= {8'b0, sh[31:8]};
          cnt <= cnt + 8'd1;
          if (cnt == 8'd3) state <= S_NEXT;
        end
        S_NEXT: begin
          ptr   <= nxt(sel);
          state <= S_SAVE_RD;
        end
        S_LOAD: if (sel_full) begin
          cnt <= cnt + 8'd1;
          if (cnt == len - 8'd1) begin
            state     <= S_DONE;
            done      <= 1'b1;
            from_rom  <= 1'b0;
            low_pri   <= 1'b1;
            boot_iptr <= MEM_START;
            boot_wptr <= end_wptr;
            boot_link <= sel;
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0; mem_be = '0;
    tx_valid = '0;
    tx_byte  = sh[7:0];
    case (state)
      S_SAVE_RD: begin mem_req = 1'b1; mem_addr = MEM_START; end
      S_SCRATCH: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = MEM_START;
        mem_wdata = {24'b0, first}; mem_be = 4'b0001;
      end
      S_RESTORE: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = MEM_START;
        mem_wdata = saved; mem_be = 4'b1111;
      end
      S_POKE: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = addr_q & ~32'd3;
        mem_wdata = sh; mem_be = 4'b1111;
      end
      S_PEEK_RD: begin mem_req = 1'b1; mem_addr = addr_q & ~32'd3; end
      S_PEEK_TX: tx_valid[sel] = 1'b1;
      S_LOAD: if (sel_full) begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = load_addr & ~32'd3;
        mem_wdata = {4{cur}}; mem_be = 4'b0001 << load_addr[1:0];
      end
      default: ;
    endcase
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (rx_full == '0 && !done));

  assert_single_tx_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_valid));

  assert_byte_enables_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be == 4'b1111 || $countones(mem_be) == 1));

  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_rom_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && rom_boot) |=>
      (done && from_rom && boot_iptr == MAX_INT - 32'd2));

endmodule

// File: tb/test_link_boot_loader.sv
module test_link_boot_loader;
  localparam logic [31:0] MS = 32'h8000_0070;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, rom_boot = 1'b0;
  logic rxv [4];
  logic [7:0] rxb [4];
  logic [3:0] rx_valid, rx_full, tx_valid, mem_be;
  logic [31:0] rx_byte;
  logic [7:0] tx_byte;
  logic mem_req, mem_we, done, from_rom, low_pri;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, boot_iptr, boot_wptr;
  logic [1:0] boot_link;
  logic [31:0] mem [256];

  int checks = 0, errors = 0;
  logic [33:0] exp_q [$];
  logic [31:0] acc = '0;
  int nb = 0;

  always #5 clk = ~clk;

  assign rx_valid = {rxv[3], rxv[2], rxv[1], rxv[0]};
  assign rx_byte  = {rxb[3], rxb[2], rxb[1], rxb[0]};

  link_boot_loader i_link_boot_loader (
    .clk(clk), .rst(rst), .start(start), .rom_boot(rom_boot),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_full(rx_full),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .done(done), .from_rom(from_rom), .low_pri(low_pri),
    .boot_iptr(boot_iptr), .boot_wptr(boot_wptr), .boot_link(boot_link)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else mem_rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (|tx_valid) begin
      for (int l = 0; l < 4; l++) if (tx_valid[l]) begin
        acc[8*nb +: 8] = tx_byte;
        nb++;
        if (nb == 4) begin
          nb = 0;
          if (exp_q.size() == 0) chk("R4 unexpected reply", {30'b0, 2'(l)}, 32'hFFFF_FFFF);
          else begin
            chk("R2 reply link order", {30'b0, 2'(l)}, {30'b0, exp_q[0][33:32]});
            chk("R4/R9 reply word", acc, exp_q[0][31:0]);
            void'(exp_q.pop_front());
          end
        end
      end
    end
  end

  task automatic send(int l, logic [7:0] b);
    @(negedge clk);
    while (rx_full[l]) @(negedge clk);
    rxv[l] = 1'b1; rxb[l] = b;
    @(negedge clk);
    rxv[l] = 1'b0;
  endtask

  task automatic send_word(int l, logic [31:0] w);
    for (int k = 0; k < 4; k++) send(l, w[8*k +: 8]);
  endtask

  task automatic peek(int l, logic [31:0] a, logic [31:0] expv);
    exp_q.push_back({2'(l), expv});
    send(l, 8'd1);
    send_word(l, a);
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    for (int l = 0; l < 4; l++) begin rxv[l] = 1'b0; rxb[l] = '0; end
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[8'h1C] = 32'hCAFE_F00D;
    mem[8'h1D] = 32'hAABB_CCDD;
    mem[8'h41] = 32'h5A5A_0001;
    repeat (3) @(negedge clk);
    rxv[1] = 1'b1; rxb[1] = 8'h77;
    @(negedge clk);
    rxv[1] = 1'b0;
    @(negedge clk);
    chk("R1 rx_full in reset", {28'b0, rx_full}, 32'h0);
    chk("R1 done in reset", {31'b0, done}, 32'h0);
    chk("R1 no traffic in reset", {27'b0, mem_req, tx_valid}, 32'h0);

    // ROM strap run
    rst = 1'b0; rom_boot = 1'b1;
    send(2, 8'h55);
    chk("R10 byte held", {28'b0, rx_full}, 32'h4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done", {30'b0, done, from_rom}, 32'h3);
    chk("R8 entry", boot_iptr, 32'h7FFF_FFFD);
    chk("R8 workspace", boot_wptr, MS);
    repeat (3) @(negedge clk);
    chk("R8 link byte not consumed", {28'b0, rx_full}, 32'h4);
    chk("R8 memory untouched", mem[8'h1C], 32'hCAFE_F00D);

    // link boot run
    rst = 1'b1; rom_boot = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    exp_q.push_back({2'd1, 32'hCAFE_F00D});
    exp_q.push_back({2'd3, 32'h5A5A_0001});
    fork send(1, 8'd1); send(3, 8'd1); join
    chk("R10 two links held", {28'b0, rx_full}, 32'hA);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork send_word(1, MS); send_word(3, 32'h8000_0104); join
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    send(2, 8'd0);
    send_word(2, 32'h8000_0100);
    send_word(2, 32'h1122_3344);
    repeat (10) @(negedge clk);
    chk("R3 poked word", mem[8'h40], 32'h1122_3344);
    peek(0, 32'h8000_0100, 32'h1122_3344);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9 MemStart restored", mem[8'h1C], 32'hCAFE_F00D);

    send(2, 8'd6);
    while (rx_full[2]) @(negedge clk);
    send(0, 8'd0);
    for (int k = 0; k < 6; k++) send(2, 8'h10 + 8'(k));
    while (!done) @(negedge clk);
    chk("R5 first boot word", mem[8'h1C], 32'h1312_1110);
    chk("R5 partial word lanes", mem[8'h1D], 32'hAABB_1514);
    chk("R6 other link not consumed", {31'b0, rx_full[0]}, 32'h1);
    chk("R7 entry", boot_iptr, MS);
    chk("R7 link", {30'b0, boot_link}, 32'h2);
    chk("R7 workspace", boot_wptr, 32'h8000_0078);
    chk("R7 flags", {30'b0, low_pri, from_rom}, 32'h2);
    repeat (5) @(negedge clk);
    chk("R6 no stray write", mem[8'h40], 32'h1122_3344);
    chk("R7 done held", {31'b0, done}, 32'h1);
    chk("R4 queue drained", exp_q.size(), 32'h0);
    finish_sim();
  end
endmodule